// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is written into a one-entry holding register with a data bus and a strobe. The block moves it into a shift register and sends a frame: a Low start bit, the data bits least significant first, an optional parity bit, then a High stop period. Between frames the line rests High.

The frame format comes from run-time line-control inputs: the data length (5 to 8 bits), parity enable, parity sense, and an extended-stop control. That control gives one and a half stop bits when the length is 5 and two stop bits for any longer length. All bit timing is counted in pulses of an externally supplied enable at sixteen times the baud rate, so a full bit lasts 16 pulses and the half stop bit is timed in those same pulses. A character written while a frame is on the line waits in the holding register and goes out immediately after the current stop period, with no idle gap.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_out` is 1, `busy` is 0 and `hold_empty` is 1.
- R2: A write accepted while idle (strobe sampled at clock edge E) takes effect at edge E+1, where `tx_out` goes to 0 for a start bit lasting 16 tick pulses.
- R3: `cfg_len` selects the data length (0 = 5 bits, 1 = 6, 2 = 7, 3 = 8). Data bits are sent least significant first, and bits of `wr_data` above the selected length are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the last data bit. With `cfg_par_even` = 1 it makes the count of ones in data plus parity even, so 0x3A with 8 bits gives 0; with `cfg_par_even` = 0 it makes that count odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: The stop period is High for 16 tick pulses when `cfg_stop_ext` is 0. When `cfg_stop_ext` is 1, it lasts 24 pulses for a data length of 5 and 32 pulses for any other length.
- R6: Every start, data and parity bit lasts exactly 16 tick pulses. During a frame the line changes only at a clock edge where `tick` is 1, so without pulses the line holds its level.
- R7: A character written while a frame is in progress is held. Its start bit begins at the same edge at which the current stop period ends.
- R8: A write that arrives while the holding register is full and is not being emptied that cycle is dropped, and the held character is kept.
- R9: The line-control inputs are sampled when a frame starts. Changing them during a frame does not alter that frame.
- R10: `busy` is 1 from the edge that accepts a write until the line has returned to idle after the last stop period. `hold_empty` is 0 while a character waits in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable pulse at 16 times the baud rate |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | MAX_DATA (8) | Character to send |
| cfg_len | input | LEN_W (2) | Data length code, 0 = 5 bits through 3 = 8 bits |
| cfg_par_en | input | 1 | Adds a parity bit when 1 |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop_ext | input | 1 | 0 = one stop bit, 1 = 1.5 stop bits (5-bit data) or two stop bits (longer data) |
| tx_out | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress or character waiting |
| hold_empty | output | 1 | Holding register can take a character |

## Verification
The bench drives `tick` on every other clock, so a full bit spans 32 clocks. The line falls on the second clock edge after the write strobe is sampled, and each bit decision is sampled on a falling clock edge 16 clocks into that bit. Back-to-back frames begin on a tick edge, so the bench measures the full frame length of a held character as the exact clock count between two load events, which it observes as `hold_empty` rising while the line goes Low. That count must equal twice the expected number of tick pulses. Dropped writes, mid-frame format changes and a stalled tick are each judged from the decoded line or the status outputs before the next stimulus is applied.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_t;

   // Line level for a given frame phase.
   function automatic logic line_level(tx_state_t s, logic data_bit, logic par_bit);
      case (s)
         ST_START: line_level = 1'b0;
         ST_DATA:  line_level = data_bit;
         ST_PAR:   line_level = par_bit;
         default:  line_level = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_data,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] data
);

   logic accept;

   // A write lands when the slot is free or is being emptied this cycle.
   assign accept = wr_stb && (!full || take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (accept) begin
            full <= 1'b1;
            data <= wr_data;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sertx_tick_timer.sv
module sertx_tick_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] last_cnt,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   assign done = tick && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int MAX_DATA = 8,
   parameter int MIN_DATA = 5,
   parameter int LEN_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [MAX_DATA-1:0] din,
   input  logic [LEN_W-1:0]    len,
   input  logic                par_even,
   input  logic                shift,
   output logic                bit_out,
   output logic                par_bit
);

   logic [MAX_DATA-1:0] mask;
   logic [MAX_DATA-1:0] masked;
   logic [MAX_DATA-1:0] sh_q;
   logic                par_q;

   // Bits below the minimum length are always sent; the rest depend on len.
   for (genvar i = 0; i < MAX_DATA; i++) begin : g_mask
      if (i < MIN_DATA) begin : g_fixed
         assign mask[i] = 1'b1;
      end else begin : g_sel
         assign mask[i] = (len >= LEN_W'(i - MIN_DATA + 1));
      end
   end

   assign masked  = din & mask;
   assign bit_out = sh_q[0];
   assign par_bit = par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         par_q <= 1'b0;
      end else if (load) begin
         sh_q  <= masked;
         par_q <= (^masked) ^ ~par_even;
      end else if (shift) begin
         sh_q  <= sh_q >> 1;
      end
   end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int MIN_DATA = 5,
   parameter int MAX_DATA = 8,
   parameter int OVS      = 16,
   parameter bit OUT_REG  = 1'b0,
   localparam int LEN_W   = $clog2(MAX_DATA - MIN_DATA + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                wr_stb,
   input  logic [MAX_DATA-1:0] wr_data,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic                cfg_par_en,
   input  logic                cfg_par_even,
   input  logic                cfg_stop_ext,
   output logic                tx_out,
   output logic                busy,
   output logic                hold_empty
);

   localparam int CNT_W = $clog2(2 * OVS);
   localparam int IDX_W = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1;
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS + OVS / 2 - 1);
   localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVS - 1);

   // Elaboration-time parameter checks
   if (MAX_DATA <= MIN_DATA) begin : g_bad_len
      $error("sertx_top: MAX_DATA must exceed MIN_DATA");
   end
   if (MIN_DATA < 1) begin : g_bad_min
      $error("sertx_top: MIN_DATA must be at least 1");
   end
   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("sertx_top: OVS must be even and at least 2");
   end

   tx_state_t          state_q;
   logic [LEN_W-1:0]   len_q;
   logic               pe_q;
   logic               stx_q;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   last_idx;
   logic [CNT_W-1:0]   last_cnt;
   logic               hold_full;
   logic [MAX_DATA-1:0] hold_data;
   logic               launch;
   logic               tdone;
   logic               frame_on;
   logic               data_bit;
   logic               par_bit;
   logic               line_d;

   assign frame_on = (state_q != ST_IDLE);
   assign launch   = hold_full && (!frame_on || (state_q == ST_STOP && tdone));
   assign last_idx = IDX_W'(MIN_DATA - 1) + IDX_W'(len_q);

   // Terminal count of the current phase; only the stop phase varies.
   always_comb begin
      last_cnt = BIT_LAST;
      if (state_q == ST_STOP && stx_q) begin
         last_cnt = (len_q == '0) ? HALF_LAST : TWO_LAST;
      end
   end

   sertx_hold #(.W(MAX_DATA)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .take    (launch),
      .full    (hold_full),
      .data    (hold_data)
   );

   sertx_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (launch),
      .tick     (tick && frame_on),
      .last_cnt (last_cnt),
      .done     (tdone)
   );

   sertx_shift #(
      .MAX_DATA (MAX_DATA),
      .MIN_DATA (MIN_DATA),
      .LEN_W    (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .din      (hold_data),
      .len      (cfg_len),
      .par_even (cfg_par_even),
      .shift    (state_q == ST_DATA && tdone),
      .bit_out  (data_bit),
      .par_bit  (par_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         pe_q    <= 1'b0;
         stx_q   <= 1'b0;
         idx_q   <= '0;
      end else if (launch) begin
         state_q <= ST_START;
         len_q   <= cfg_len;
         pe_q    <= cfg_par_en;
         stx_q   <= cfg_stop_ext;
         idx_q   <= '0;
      end else if (tdone) begin
         case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
               if (idx_q == last_idx) begin
                  state_q <= pe_q ? ST_PAR : ST_STOP;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_PAR:  state_q <= ST_STOP;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign line_d     = line_level(state_q, data_bit, par_bit);
   assign busy       = hold_full || frame_on;
   assign hold_empty = !hold_full;

   if (OUT_REG) begin : g_out_reg
      logic tx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tx_q <= 1'b1;
         else        tx_q <= line_d;
      end
      assign tx_out = tx_q;
   end else begin : g_out_comb
      assign tx_out = line_d;
   end

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic wr_stb,
   input logic tx_out,
   input logic busy,
   input logic hold_empty,
   input logic frame_on
);

   // R1: line rests High when nothing is pending or sending
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_out);

   // R2: the edge after busy rises puts the start bit on the line
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> !tx_out);

   // R6: inside a frame the line moves only on tick edges
   a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_on && !tick) |=> $stable(tx_out));

   // R10: an accepted write fills the holding register
   a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && hold_empty) |=> !hold_empty);

   // R10: a waiting character keeps busy asserted
   a_r10_waiting_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_empty |-> busy);

   // R5: the stop period can only end on a tick edge
   a_r5_stop_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));

endmodule

bind sertx_top sertx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .wr_stb     (wr_stb),
   .tx_out     (tx_out),
   .busy       (busy),
   .hold_empty (hold_empty),
   .frame_on   (frame_on)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

   typedef struct packed {
      logic [7:0] d;
      logic [1:0] len;
      logic       pe;
      logic       pev;
      logic       stx;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{8'h3A, 2'd3, 1'b1, 1'b1, 1'b0},
      '{8'h3A, 2'd3, 1'b1, 1'b0, 1'b1},
      '{8'h15, 2'd0, 1'b0, 1'b0, 1'b1},
      '{8'h1F, 2'd0, 1'b1, 1'b1, 1'b1},
      '{8'hC3, 2'd1, 1'b1, 1'b0, 1'b0},
      '{8'hFF, 2'd2, 1'b0, 1'b0, 1'b1},
      '{8'h80, 2'd3, 1'b0, 1'b1, 1'b0},
      '{8'hE9, 2'd0, 1'b0, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_run = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_stop_ext = 1'b0;
   logic       tx_out;
   logic       busy;
   logic       hold_empty;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   sertx_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .wr_stb       (wr_stb),
      .wr_data      (wr_data),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .cfg_stop_ext (cfg_stop_ext),
      .tx_out       (tx_out),
      .busy         (busy),
      .hold_empty   (hold_empty)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // 16x enable: one pulse every second clock
   initial begin
      forever begin
         @(negedge clk);
         tick <= tick_run ? ~tick : 1'b0;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic wait_empty();
      while (!hold_empty) @(negedge clk);
   endtask

   function automatic logic [7:0] exp_data(vec_t v);
      return v.d & (8'hFF >> (2'd3 - v.len));
   endfunction

   function automatic int stop_ticks(vec_t v);
      if (!v.stx) return 16;
      return (v.len == 2'd0) ? 24 : 32;
   endfunction

   // Called at the falling edge on which the start bit of the frame is first seen.
   task automatic decode(input vec_t v, input string tag);
      logic [7:0] got;
      int n;
      got = '0;
      n = 5 + int'(v.len);
      repeat (16) @(negedge clk);
      chk(tx_out == 1'b0, "R2 start bit", tx_out, 0);
      chk(busy == 1'b1, "R10 busy in frame", busy, 1);
      for (int i = 0; i < n; i++) begin
         repeat (32) @(negedge clk);
         got[i] = tx_out;
      end
      chk(got == exp_data(v), tag, got, exp_data(v));
      if (v.pe) begin
         repeat (32) @(negedge clk);
         chk(tx_out == ((^exp_data(v)) ^ ~v.pev), "R4 parity bit", tx_out,
             (^exp_data(v)) ^ ~v.pev);
      end
      repeat (32) @(negedge clk);
      chk(tx_out == 1'b1, "R5 stop level", tx_out, 1);
   endtask

   task automatic run_vec(input vec_t v, input bit junk, input bit flip, input string tag);
      int t0;
      int t1;
      int exp_per;
      wait_idle();
      cfg_len      = v.len;
      cfg_par_en   = v.pe;
      cfg_par_even = v.pev;
      cfg_stop_ext = v.stx;
      wr(~v.d);
      wait_empty();
      wr(v.d);
      if (junk) wr(v.d ^ 8'hFF);
      @(negedge clk);
      wait_empty();
      t0 = cyc;
      chk(tx_out == 1'b0, "R7 held frame starts at stop end", tx_out, 0);
      fork
         wr(v.d);
         decode(v, tag);
         if (flip) begin
            repeat (40) @(negedge clk);
            cfg_len    = v.len ^ 2'd1;
            cfg_par_en = ~v.pe;
            cfg_par_even = ~v.pev;
            cfg_stop_ext = ~v.stx;
         end
      join
      wait_empty();
      t1 = cyc;
      exp_per = 2 * (16 * (1 + 5 + int'(v.len) + int'(v.pe)) + stop_ticks(v));
      chk((t1 - t0) == exp_per, "R5 R6 frame length in clocks", t1 - t0, exp_per);
      wait_idle();
      chk(tx_out == 1'b1 && hold_empty, "R1 idle after frames", tx_out, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(tx_out == 1'b1, "R1 reset line level", tx_out, 1);
      chk(busy == 1'b0, "R10 reset busy", busy, 0);
      chk(hold_empty == 1'b1, "R1 reset hold empty", hold_empty, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NVEC; k++) begin
         run_vec(VECS[k], 1'b0, 1'b0, "R3 data bits");
      end

      // R2: strobe sampled at edge E, line low only after edge E+1
      wait_idle();
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop_ext = 1'b0;
      @(negedge clk);
      wr_stb = 1'b1; wr_data = 8'h00;
      @(negedge clk);
      wr_stb = 1'b0;
      chk(tx_out == 1'b1, "R2 line still high one edge after write", tx_out, 1);
      chk(busy == 1'b1, "R10 busy after accepted write", busy, 1);
      @(negedge clk);
      chk(tx_out == 1'b0, "R2 start on second edge", tx_out, 0);
      wait_idle();

      // R8: extra write while the slot holds a character is lost
      run_vec('{8'h55, 2'd3, 1'b0, 1'b0, 1'b0}, 1'b1, 1'b0, "R8 dropped write keeps held data");

      // R9: format changed mid-frame does not disturb the frame on the line
      run_vec('{8'hA6, 2'd2, 1'b1, 1'b0, 1'b0}, 1'b0, 1'b1, "R9 format held through frame");

      // R6: no tick pulses, the start bit does not advance
      wait_idle();
      tick_run = 1'b0;
      wr(8'h00);
      repeat (50) @(negedge clk);
      chk(tx_out == 1'b0, "R6 line frozen without tick", tx_out, 0);
      chk(busy == 1'b1, "R10 busy while frozen", busy, 1);
      tick_run = 1'b1;
      wait_idle();
      chk(tx_out == 1'b1, "R1 idle after frozen frame", tx_out, 1);

      finish_up();
   end

endmodule